// File: doc/BRIEF.md
# Tiled surface address translator

This block turns a pixel position on a 32-bit-per-pixel surface into the byte offset of that pixel in surface memory. The caller gives a column, a row, the row pitch in bytes, a layout code and a swizzle code. The block applies one of four layouts: plain row-major, a 512-byte by 8-row tile, a legacy 128-byte by 32-row tile built from 16-byte columns, and a 128-byte by 32-row tile made of 64-byte subtiles that are stored in a reordered sequence.

After the layout mapping, the block can fold some higher address bits into bit 6 of the offset. This swizzle is applied only to the two older tiled layouts. Requests and results pass through a two-stage valid/ready pipeline. When the output is not taken, the result stays on the output and new requests back up. A pitch that does not suit the selected layout raises an error flag that travels with the result.

Top module: `tile_addr_xlate`

## Requirements
- R1: After a synchronous reset, `outValid` is 0 and `inReady` is 1.
- R2: Layout code 0 (row-major) gives offset = y*stride + 4*x.
- R3: Layout code 1 gives offset = (y/8)*stride*8 + (y%8)*512 + (b/512)*4096 + b%512, where b = 4*x.
- R4: Layout code 2 gives offset = (y/32)*stride*32 + (y%32)*16 + (b/16)*512 + b%16, where b = 4*x.
- R5: Layout code 3 gives base + s'*64 + (r%4)*16 + c%16, where base = (y/32)*stride*32 + (b/128)*4096, c = b%128, r = y%32, s = (r/4)*8 + c/16, and s' is s with its bits 2 and 3 exchanged.
- R6: For layout codes 1 and 2, the swizzle code sets what is XORed into offset bit 6: 1 gives bit 9; 2 gives bits 9^10; 3 gives bits 9^11; 4 gives bits 9^10^11. Codes 0, 5, 6 and 7 leave the offset unchanged.
- R7: For layout codes 0 and 3, the swizzle code has no effect on the offset.
- R8: `outErr` is 1 when the stride is not a multiple of the layout's width in bytes: 4 for code 0, 512 for code 1, and 128 for codes 2 and 3. Otherwise `outErr` is 0.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid`, `outOffset` and `outErr` hold their values.
- R10: A request accepted at a clock edge shows on the output after the second following edge if the output is not stalled. `inReady` is low only when the output is valid but not taken and the first stage is also full.
- R11: When `outErr` is 0, the two low bits of `outOffset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A request is present |
| inReady | output | 1 | The request is accepted at this edge |
| inX | input | X_W | Pixel column |
| inY | input | Y_W | Pixel row |
| inStride | input | STRIDE_W | Row pitch in bytes |
| inLayout | input | 2 | Layout code, 0 to 3 |
| inSwizzle | input | 3 | Swizzle code, 0 to 7 |
| outValid | output | 1 | A result is present |
| outReady | input | 1 | The consumer takes the result |
| outOffset | output | OFS_W | Byte offset of the pixel |
| outErr | output | 1 | The pitch does not suit the layout |

## Verification
An error in a layout term shows up as a wrong offset on the result two cycles later. Each term depends on a different slice of the row and column, so a sweep over small rows and columns for every layout and every swizzle code reaches every slice. A wrong subtile exchange only shows at rows and columns where subtile bits 2 and 3 differ. A swizzle that uses the wrong bit only shows once the offset passes 512 bytes, so the sweeps use pitches large enough to get there. Faults in the handshake state show up at once in a stall test: an overwritten or dropped result changes the held output on the next edge.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    LAYOUT_LINEAR = 2'd0,
    LAYOUT_XMAJ   = 2'd1,
    LAYOUT_YMAJ   = 2'd2,
    LAYOUT_T4     = 2'd3
  } layout_e;

  localparam logic [2:0] SWZ_B9       = 3'd1;
  localparam logic [2:0] SWZ_B9_10    = 3'd2;
  localparam logic [2:0] SWZ_B9_11    = 3'd3;
  localparam logic [2:0] SWZ_B9_10_11 = 3'd4;

  typedef struct packed {
    logic load1;
    logic load2;
  } xlate_strobe_t;

  function automatic logic [5:0] subtilePerm(input logic [5:0] s);
    return {s[5:4], s[2], s[3], s[1:0]};
  endfunction

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output logic          inReady,
  input  logic          outReady,
  output logic          outValid,
  output xlate_strobe_t strobe
);

  logic stage1Valid, stage2Valid;
  logic adv1, adv2;

  always_comb begin
    adv2 = !stage2Valid || outReady;
    adv1 = !stage1Valid || adv2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      if (adv2) stage2Valid <= stage1Valid;
      if (adv1) stage1Valid <= inValid;
    end
  end

  assign inReady      = adv1;
  assign outValid     = stage2Valid;
  assign strobe.load1 = adv1 && inValid;
  assign strobe.load2 = adv2 && stage1Valid;

endmodule

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int X_W      = 14,
  parameter int Y_W      = 14,
  parameter int STRIDE_W = 18,
  parameter int OFS_W    = 32
) (
  input  logic                clk,
  input  xlate_strobe_t       strobe,
  input  logic [X_W-1:0]      inX,
  input  logic [Y_W-1:0]      inY,
  input  logic [STRIDE_W-1:0] inStride,
  input  logic [1:0]          inLayout,
  input  logic [2:0]          inSwizzle,
  output logic [OFS_W-1:0]    outOffset,
  output logic                outErr
);

  localparam int XB_W = X_W + 2;

  logic [XB_W-1:0]  xb;
  logic [Y_W-1:0]   yMask;
  logic [OFS_W-1:0] rowBase, inner;
  logic [5:0]       subIdx;
  logic             strideBad;
  logic             swzAllowed;

  // stage 1: split coordinates into row base and intra-tile part
  always_comb begin
    xb         = {inX, 2'b00};
    subIdx     = {inY[4:2], xb[6:4]};
    yMask      = inY;
    inner      = OFS_W'(xb);
    strideBad  = 1'b0;
    swzAllowed = 1'b0;
    case (layout_e'(inLayout))
      LAYOUT_LINEAR: begin
        strideBad = |inStride[1:0];
      end
      LAYOUT_XMAJ: begin
        yMask      = inY & ~Y_W'(7);
        inner      = (OFS_W'(inY[2:0]) << 9)
                   + (OFS_W'(xb[XB_W-1:9]) << 12)
                   + OFS_W'(xb[8:0]);
        strideBad  = |inStride[8:0];
        swzAllowed = 1'b1;
      end
      LAYOUT_YMAJ: begin
        yMask      = inY & ~Y_W'(31);
        inner      = (OFS_W'(inY[4:0]) << 4)
                   + (OFS_W'(xb[XB_W-1:4]) << 9)
                   + OFS_W'(xb[3:0]);
        strideBad  = |inStride[6:0];
        swzAllowed = 1'b1;
      end
      default: begin
        yMask      = inY & ~Y_W'(31);
        inner      = (OFS_W'(xb[XB_W-1:7]) << 12)
                   + (OFS_W'(subtilePerm(subIdx)) << 6)
                   + (OFS_W'(inY[1:0]) << 4)
                   + OFS_W'(xb[3:0]);
        strideBad  = |inStride[6:0];
      end
    endcase
    rowBase = OFS_W'(yMask) * OFS_W'(inStride);
  end

  logic [OFS_W-1:0] rowBase1, inner1;
  logic             err1, swzOn1;
  logic [2:0]       swz1;

  always_ff @(posedge clk) begin
    if (strobe.load1) begin
      rowBase1 <= rowBase;
      inner1   <= inner;
      err1     <= strideBad;
      swzOn1   <= swzAllowed;
      swz1     <= inSwizzle;
    end
  end

  // stage 2: sum and bit-6 fold
  logic [OFS_W-1:0] sum, folded;
  logic             flip;

  always_comb begin
    sum = rowBase1 + inner1;
    case (swz1)
      SWZ_B9:       flip = sum[9];
      SWZ_B9_10:    flip = sum[9] ^ sum[10];
      SWZ_B9_11:    flip = sum[9] ^ sum[11];
      SWZ_B9_10_11: flip = sum[9] ^ sum[10] ^ sum[11];
      default:      flip = 1'b0;
    endcase
    folded    = sum;
    folded[6] = sum[6] ^ (flip && swzOn1);
  end

  always_ff @(posedge clk) begin
    if (strobe.load2) begin
      outOffset <= folded;
      outErr    <= err1;
    end
  end

endmodule

// File: rtl/tile_addr_xlate.sv
module tile_addr_xlate
  import xlate_pkg::*;
#(
  parameter int X_W      = 14,
  parameter int Y_W      = 14,
  parameter int STRIDE_W = 18,
  parameter int OFS_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic [X_W-1:0]      inX,
  input  logic [Y_W-1:0]      inY,
  input  logic [STRIDE_W-1:0] inStride,
  input  logic [1:0]          inLayout,
  input  logic [2:0]          inSwizzle,
  output logic                outValid,
  input  logic                outReady,
  output logic [OFS_W-1:0]    outOffset,
  output logic                outErr
);

  xlate_strobe_t strobe;

  xlate_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  xlate_datapath #(
    .X_W(X_W), .Y_W(Y_W), .STRIDE_W(STRIDE_W), .OFS_W(OFS_W)
  ) i_dp (
    .clk       (clk),
    .strobe    (strobe),
    .inX       (inX),
    .inY       (inY),
    .inStride  (inStride),
    .inLayout  (inLayout),
    .inSwizzle (inSwizzle),
    .outOffset (outOffset),
    .outErr    (outErr)
  );

endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int OFS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [OFS_W-1:0] outOffset,
  input logic             outErr
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outOffset) && $stable(outErr));

  assert_stall_only_R10: assert property (@(posedge clk) disable iff (rst)
    !inReady |-> outValid && !outReady);

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) ##1 outReady |=> outValid);

  assert_aligned_R11: assert property (@(posedge clk) disable iff (rst)
    outValid && !outErr |-> outOffset[1:0] == 2'b00);

endmodule

bind tile_addr_xlate xlate_checker #(.OFS_W(OFS_W)) i_checker (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady),
  .outOffset(outOffset), .outErr(outErr)
);

// File: tb/test_tile_addr_xlate.sv
module test_tile_addr_xlate;

  localparam int X_W = 14, Y_W = 14, STRIDE_W = 18, OFS_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inReady, outValid, outReady = 1'b1, outErr;
  logic [X_W-1:0] inX = '0;
  logic [Y_W-1:0] inY = '0;
  logic [STRIDE_W-1:0] inStride = '0;
  logic [1:0] inLayout = '0;
  logic [2:0] inSwizzle = '0;
  logic [OFS_W-1:0] outOffset;

  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  tile_addr_xlate #(.X_W(X_W), .Y_W(Y_W), .STRIDE_W(STRIDE_W), .OFS_W(OFS_W))
    i_tile_addr_xlate (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic longint bitOf(input longint v, input int n);
    return (v >> n) & 1;
  endfunction

  function automatic longint model(input int x, input int y, input int st,
                                   input int lay, input int swz);
    longint b, v, base, c, r, s, b2, b3, sp, f;
    b = 4 * x;
    case (lay)
      0: v = longint'(y) * st + b;
      1: v = (y / 8) * longint'(st) * 8 + (y % 8) * 512 + (b / 512) * 4096 + b % 512;
      2: v = (y / 32) * longint'(st) * 32 + (y % 32) * 16 + (b / 16) * 512 + b % 16;
      default: begin
        base = (y / 32) * longint'(st) * 32 + (b / 128) * 4096;
        c = b % 128; r = y % 32;
        s = (r / 4) * 8 + c / 16;
        b2 = (s / 4) % 2; b3 = (s / 8) % 2;
        sp = s - b2 * 4 - b3 * 8 + b2 * 8 + b3 * 4;
        v = base + sp * 64 + (r % 4) * 16 + c % 16;
      end
    endcase
    f = 0;
    if (lay == 1 || lay == 2) begin
      case (swz)
        1: f = bitOf(v, 9);
        2: f = bitOf(v, 9) ^ bitOf(v, 10);
        3: f = bitOf(v, 9) ^ bitOf(v, 11);
        4: f = bitOf(v, 9) ^ bitOf(v, 10) ^ bitOf(v, 11);
        default: f = 0;
      endcase
    end
    return (v ^ (f << 6)) & 64'hFFFF_FFFF;
  endfunction

  function automatic string layTag(input int lay, input int swz);
    if (swz != 0) return (lay == 1 || lay == 2) ? "R6" : "R7";
    case (lay)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic drive(input int x, input int y, input int st, input int lay, input int swz);
    inX = X_W'(x); inY = Y_W'(y); inStride = STRIDE_W'(st);
    inLayout = 2'(lay); inSwizzle = 3'(swz); inValid = 1'b1;
  endtask

  task automatic run1(input int x, input int y, input int st, input int lay, input int swz);
    @(negedge clk); drive(x, y, st, lay, swz);
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);
    if (!outValid) check("R10", outValid, 1);
    check(layTag(lay, swz), outOffset, model(x, y, st, lay, swz));
  endtask

  task automatic runErr(input int st, input int lay, input int exp);
    @(negedge clk); drive(3, 5, st, lay, 0);
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);
    check("R8", outErr, exp);
  endtask

  longint heldA;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 outValid", outValid, 0);
    check("R1 inReady", inReady, 1);

    // R10 latency
    @(negedge clk); drive(9, 17, 2048, 1, 0);
    @(negedge clk); inValid = 1'b0;
    check("R10 after one edge", outValid, 0);
    @(negedge clk);
    check("R10 after two edges", outValid, 1);
    check("R3", outOffset, model(9, 17, 2048, 1, 0));

    // R2..R5 main sweeps
    for (int lay = 0; lay < 4; lay++)
      for (int y = 0; y < 64; y++)
        for (int x = 0; x < 160; x += 3)
          run1(x, y, 2048, lay, 0);

    // R6 R7 swizzle codes across layouts
    for (int swz = 1; swz < 8; swz++)
      for (int lay = 0; lay < 4; lay++)
        for (int y = 0; y < 64; y += 5)
          for (int x = 0; x < 160; x += 13)
            run1(x, y, 1536, lay, swz);

    // R8 stride checks
    runErr(1000, 1, 1);
    runErr(2048 + 128, 1, 1);
    runErr(2048 + 128, 2, 0);
    runErr(2048 + 64, 3, 1);
    runErr(2048 + 128, 3, 0);
    runErr(6, 0, 1);
    runErr(12, 0, 0);
    runErr(1536, 1, 0);

    // R9 stall and backpressure
    @(negedge clk); outReady = 1'b0; drive(7, 3, 2048, 2, 1);
    @(negedge clk); drive(40, 40, 2048, 3, 0);
    @(negedge clk); drive(100, 9, 2048, 1, 3);
    heldA = model(7, 3, 2048, 2, 1);
    check("R9 valid while stalled", outValid, 1);
    check("R9 first result", outOffset, heldA);
    check("R10 inReady low when full", inReady, 0);
    repeat (3) @(negedge clk);
    check("R9 held offset", outOffset, heldA);
    check("R9 held valid", outValid, 1);
    outReady = 1'b1;
    @(negedge clk); inValid = 1'b0;
    check("R9 second result", outOffset, model(40, 40, 2048, 3, 0));
    @(negedge clk);
    check("R9 third result", outOffset, model(100, 9, 2048, 1, 3));
    @(negedge clk);
    check("R10 drained", outValid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule